// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block records sixteen digital channels into an external static RAM at the full sample rate. Each pair of consecutive 16-bit samples is packed into one 32-bit word, so the RAM, built as two 16-bit parts side by side, sees one write every second sample. With 150 MHz sampling, the RAM is written at 75 MHz. Sampling runs on every system clock, or on every rising edge of an external sample clock. The external clock is synchronized into the system clock domain, so in that mode it must be well below the system clock rate.

A processor issues an arm command. The block then waits for a rising edge on the external trigger. From that edge it stores samples until the last RAM location has been written, and then it stops. Three flags report the capture state to the processor: started, done and full. The RAM port is also used by another acquisition path. For that reason the block drives the data lines only while it captures, and drives the address lines only while it captures or reads back. When the block is idle, the processor can read the stored words back through the same port.

Top module: `lacap_top`

## Requirements
- R1: After reset, the started, done and full flags are 0, no write strobe is issued, and the address and data lines are released (memAddrEn = 0, memDataEn = 0).
- R2: An arm command given while idle clears started, done and full, and prepares a new capture that begins at word address 0.
- R3: Once armed, capture starts only on a rising edge of trigIn (low in one cycle, high in the next). A trigger that is already high when arming happens does not start capture. The started flag rises with the trigger edge, and samples taken before it are never written.
- R4: In each stored word, bits [15:0] hold the earlier sample of the pair and bits [31:16] hold the later one. The first sample stored is the one taken on the first sample event after the trigger edge.
- R5: Each capture writes word addresses 0, 1, 2 and so on, one write per sample pair. The address counter wraps to 0 after the top address.
- R6: When the word at address 2^AW−1 has been written, full and done are set, capture stops, and no further write strobe is issued.
- R7: An arm command is ignored while the block is armed or capturing. The address sequence, the stored data and the flags continue unchanged.
- R8: With extSel = 1, exactly one sample is taken per rising edge of extSmpIn. With extSel = 0, one sample is taken every clock.
- R9: While idle with cmdRead = 1, memAddr follows rdAddr, the data lines stay released, and rdData shows memDin for that address after the next clock edge.
- R10: memDataEn is high only while capturing or while a write strobe is active. memAddrEn is high only then or during readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| chanIn | input | CH | Channel inputs |
| trigIn | input | 1 | External trigger, active on its rising edge |
| extSel | input | 1 | 1 = sample on rising edges of extSmpIn |
| extSmpIn | input | 1 | External sample clock |
| cmdArm | input | 1 | Arm command pulse |
| cmdRead | input | 1 | Readback mode request |
| rdAddr | input | AW | Readback word address |
| memDin | input | 2*CH | Data returned by the RAM |
| memAddr | output | AW | RAM word address |
| memAddrEn | output | 1 | Address line drive enable |
| memDout | output | 2*CH | Packed word to the RAM |
| memDataEn | output | 1 | Data line drive enable |
| memWe | output | 1 | RAM write strobe |
| rdData | output | 2*CH | Readback word to the bus |
| stStarted | output | 1 | Capture started flag |
| stDone | output | 1 | Capture finished flag |
| stFull | output | 1 | Memory full flag |

## Verification
The main capture runs three times with random channel data: once with the internal sample rate, once with the external sample clock, and once more to confirm that a new arm restarts at address 0. Random data catches swapped halves and samples that are dropped or repeated within a pair. This is because a half-word lands at the wrong address only if packing or pairing is broken. Random junk is driven before the trigger, with random lengths. This shows whether pre-trigger samples leak into memory and whether a trigger that is already high is wrongly taken as an edge. An arm pulse in the middle of a capture, and samples still driven after the memory is full, show whether the block ignores those events or restarts and overwrites.

// File: rtl/lacap_pkg.sv
package lacap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2
  } capState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAddr;
    logic takeLo;
    logic writeWord;
    logic capture;
    logic readMode;
  } dpStrobe_t;

endpackage

// File: rtl/lacap_smpsel.sv
module lacap_smpsel (
  input  logic clk,
  input  logic rstN,
  input  logic extSel,
  input  logic extSmpIn,
  output logic smpTick
);
  logic [2:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], extSmpIn};
  end

  always_comb begin
    if (extSel) smpTick = syncQ[1] & ~syncQ[2];
    else        smpTick = 1'b1;
  end

  // R8: in external mode a tick never lasts two cycles
  a_r8_single_tick: assert property (@(posedge clk) disable iff (!rstN)
    (extSel && $past(extSel) && smpTick) |=> !smpTick);
endmodule

// File: rtl/lacap_ctrl.sv
module lacap_ctrl
  import lacap_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdArm,
  input  logic      cmdRead,
  input  logic      trigIn,
  input  logic      smpTick,
  input  logic      lastAddr,
  output dpStrobe_t str,
  output logic      stStarted,
  output logic      stDone,
  output logic      stFull
);
  capState_t state;
  logic trigPrev;
  logic phase;
  logic trigRise;
  logic armOk;
  logic finish;

  assign trigRise = trigIn & ~trigPrev;
  assign armOk    = cmdArm && (state == ST_IDLE);
  assign finish   = str.writeWord && lastAddr;

  always_comb begin
    str           = '0;
    str.clrAddr   = armOk;
    str.capture   = (state == ST_CAPT);
    str.takeLo    = (state == ST_CAPT) && smpTick && !phase;
    str.writeWord = (state == ST_CAPT) && smpTick && phase;
    str.readMode  = (state == ST_IDLE) && cmdRead && !cmdArm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      trigPrev  <= 1'b0;
      phase     <= 1'b0;
      stStarted <= 1'b0;
      stDone    <= 1'b0;
      stFull    <= 1'b0;
    end else begin
      trigPrev <= trigIn;
      case (state)
        ST_IDLE: begin
          if (armOk) begin
            state     <= ST_ARMED;
            phase     <= 1'b0;
            stStarted <= 1'b0;
            stDone    <= 1'b0;
            stFull    <= 1'b0;
          end
        end
        ST_ARMED: begin
          if (trigRise) begin
            state     <= ST_CAPT;
            stStarted <= 1'b1;
          end
        end
        ST_CAPT: begin
          if (str.takeLo)    phase <= 1'b1;
          if (str.writeWord) phase <= 1'b0;
          if (finish) begin
            state  <= ST_IDLE;
            stDone <= 1'b1;
            stFull <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r2_arm_clears: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdArm) |=> (!stDone && !stFull && !stStarted && state == ST_ARMED));
  a_r3_start_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && trigIn && !trigPrev) |=> (stStarted && state == ST_CAPT));
  a_r3_no_start_without_edge: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && !(trigIn && !trigPrev)) |=> (state == ST_ARMED && !stStarted));
  a_r6_stop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (str.writeWord && lastAddr) |=> (state == ST_IDLE && stFull && stDone));
  a_r7_arm_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAPT && cmdArm && !(str.writeWord && lastAddr)) |=> (state == ST_CAPT));
endmodule

// File: rtl/lacap_dpath.sv
module lacap_dpath
  import lacap_pkg::*;
#(
  parameter int CH = 16,
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     str,
  input  logic [CH-1:0] chanIn,
  input  logic [AW-1:0] rdAddr,
  input  logic [2*CH-1:0] memDin,
  output logic          lastAddr,
  output logic [AW-1:0] memAddr,
  output logic          memAddrEn,
  output logic [2*CH-1:0] memDout,
  output logic          memDataEn,
  output logic          memWe,
  output logic [2*CH-1:0] rdData
);
  localparam int WW = 2 * CH;

  logic [AW-1:0] wordAddr;
  logic [AW-1:0] outAddr;
  logic [CH-1:0] loReg;
  logic          rdSel;

  assign lastAddr = &wordAddr;
  assign rdSel    = str.readMode && !memWe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddr <= '0;
      outAddr  <= '0;
      loReg    <= '0;
      memDout  <= '0;
      memWe    <= 1'b0;
      rdData   <= '0;
    end else begin
      memWe <= str.writeWord;
      if (str.clrAddr) wordAddr <= '0;
      if (str.takeLo)  loReg <= chanIn;
      if (str.writeWord) begin
        memDout  <= {chanIn, loReg};
        outAddr  <= wordAddr;
        wordAddr <= wordAddr + 1'b1;
      end
      if (rdSel) rdData <= memDin;
    end
  end

  always_comb begin
    memAddr   = rdSel ? rdAddr : outAddr;
    memDataEn = str.capture | memWe;
    memAddrEn = str.capture | memWe | rdSel;
  end

  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    str.writeWord |=> (memWe && memAddr == $past(wordAddr)));
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rstN)
    (str.writeWord && lastAddr) |=> (wordAddr == '0));
  a_r10_we_drives: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memDataEn && memAddrEn));
  a_r9_read_released: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel && !str.capture) |-> (!memDataEn && memAddrEn));
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    rdSel |=> (rdData == $past(memDin)));
  a_r4_pack_order: assert property (@(posedge clk) disable iff (!rstN)
    str.writeWord |=> (memDout[WW-1:CH] == $past(chanIn)));
endmodule

// File: rtl/lacap_top.sv
module lacap_top
  import lacap_pkg::*;
#(
  parameter int CH = 16,
  parameter int AW = 18
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [CH-1:0]   chanIn,
  input  logic            trigIn,
  input  logic            extSel,
  input  logic            extSmpIn,
  input  logic            cmdArm,
  input  logic            cmdRead,
  input  logic [AW-1:0]   rdAddr,
  input  logic [2*CH-1:0] memDin,
  output logic [AW-1:0]   memAddr,
  output logic            memAddrEn,
  output logic [2*CH-1:0] memDout,
  output logic            memDataEn,
  output logic            memWe,
  output logic [2*CH-1:0] rdData,
  output logic            stStarted,
  output logic            stDone,
  output logic            stFull
);
  dpStrobe_t str;
  logic smpTick;
  logic lastAddr;

  lacap_smpsel u_smpsel (
    .clk(clk), .rstN(rstN), .extSel(extSel), .extSmpIn(extSmpIn), .smpTick(smpTick)
  );

  lacap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdArm(cmdArm), .cmdRead(cmdRead), .trigIn(trigIn),
    .smpTick(smpTick), .lastAddr(lastAddr), .str(str),
    .stStarted(stStarted), .stDone(stDone), .stFull(stFull)
  );

  lacap_dpath #(.CH(CH), .AW(AW)) u_dpath (
    .clk(clk), .rstN(rstN), .str(str), .chanIn(chanIn), .rdAddr(rdAddr),
    .memDin(memDin), .lastAddr(lastAddr), .memAddr(memAddr), .memAddrEn(memAddrEn),
    .memDout(memDout), .memDataEn(memDataEn), .memWe(memWe), .rdData(rdData)
  );

  a_r1_flags_low_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> (!stStarted && !stDone && !stFull && !memWe));
endmodule

// File: tb/lacap_top_tb.sv
module lacap_top_tb;
  localparam int CH = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int NS = 2 * DEPTH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CH-1:0] chanIn = '0;
  logic trigIn = 1'b0, extSel = 1'b0, extSmpIn = 1'b0, cmdArm = 1'b0, cmdRead = 1'b0;
  logic [AW-1:0] rdAddr = '0;
  logic [2*CH-1:0] memDin;
  logic [AW-1:0] memAddr;
  logic memAddrEn, memDataEn, memWe, stStarted, stDone, stFull;
  logic [2*CH-1:0] memDout, rdData;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  int addrErr = 0;
  logic [2*CH-1:0] ram [DEPTH];
  logic [CH-1:0] smp [NS];

  always #2 clk = ~clk;

  lacap_top #(.CH(CH), .AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .trigIn(trigIn), .extSel(extSel),
    .extSmpIn(extSmpIn), .cmdArm(cmdArm), .cmdRead(cmdRead), .rdAddr(rdAddr),
    .memDin(memDin), .memAddr(memAddr), .memAddrEn(memAddrEn), .memDout(memDout),
    .memDataEn(memDataEn), .memWe(memWe), .rdData(rdData),
    .stStarted(stStarted), .stDone(stDone), .stFull(stFull)
  );

  assign memDin = ram[memAddr];

  always @(posedge clk) begin
    if (memWe) begin
      if (!memDataEn || !memAddrEn) addrErr <= addrErr + 1;
      if (int'(memAddr) != (wrCount % DEPTH)) addrErr <= addrErr + 1;
      ram[memAddr] <= memDout;
      wrCount <= wrCount + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*CH-1:0] expWord(input int j);
    return {smp[2*j+1], smp[2*j]};
  endfunction

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic arm();
    cmdArm = 1'b1; tick(1); cmdArm = 1'b0;
  endtask

  task automatic newSamples();
    for (int i = 0; i < NS; i++) smp[i] = CH'($urandom);
  endtask

  task automatic checkRam(input string req);
    int bad = 0;
    for (int j = 0; j < DEPTH; j++) if (ram[j] != expWord(j)) bad++;
    chk(bad == 0, req, 64'(bad), 64'd0);
  endtask

  initial begin
    int w;
    void'($urandom(32'd20240601));
    for (int j = 0; j < DEPTH; j++) ram[j] = '0;
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk(!stStarted && !stDone && !stFull, "R1 flags", {61'd0, stStarted, stDone, stFull}, 64'd0);
    chk(!memAddrEn && !memDataEn && !memWe, "R1 lines", {61'd0, memAddrEn, memDataEn, memWe}, 64'd0);

    // capture 1: internal sampling
    newSamples();
    arm();
    chk(!stStarted && !stDone && !stFull, "R2 flags after arm", {61'd0, stStarted, stDone, stFull}, 64'd0);
    w = 5 + ($urandom % 20);
    for (int i = 0; i < w; i++) begin chanIn = CH'($urandom); tick(1); end
    chk(wrCount == 0 && !stStarted, "R3 nothing before trigger", 64'(wrCount), 64'd0);
    chk(!memDataEn, "R10 released while armed", {63'd0, memDataEn}, 64'd0);
    trigIn = 1'b1; chanIn = CH'($urandom); tick(1);
    for (int i = 0; i < NS + 10; i++) begin
      chanIn = (i < NS) ? smp[i] : CH'($urandom);
      if (i == 41) cmdArm = 1'b1;   // R7 arm during capture
      if (i == 42) cmdArm = 1'b0;
      if (i == 0) chk(stStarted == 1'b1, "R3 started on edge", {63'd0, stStarted}, 64'd1);
      tick(1);
    end
    trigIn = 1'b0;
    chk(wrCount == DEPTH, "R6 write count", 64'(wrCount), 64'(DEPTH));
    chk(stFull && stDone, "R6 full and done", {62'd0, stFull, stDone}, 64'd3);
    chk(addrErr == 0, "R5 address sequence", 64'(addrErr), 64'd0);
    checkRam("R4 packing / R7 arm ignored");
    chk(!memAddrEn && !memDataEn, "R10 released when idle", {62'd0, memAddrEn, memDataEn}, 64'd0);

    // R9 readback
    cmdRead = 1'b1;
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      rdAddr = a;
      tick(1);
      chk(rdData == expWord(int'(a)), "R9 readback data", 64'(rdData), 64'(expWord(int'(a))));
      chk(memAddrEn && !memDataEn, "R9 lines in readback", {62'd0, memAddrEn, memDataEn}, 64'd2);
    end
    cmdRead = 1'b0;
    tick(1);

    // capture 2: external sample clock, trigger already high at arm
    newSamples();
    wrCount = 0;
    extSel = 1'b1;
    trigIn = 1'b1;
    arm();
    chk(!stDone && !stFull, "R2 arm clears done/full", {62'd0, stDone, stFull}, 64'd0);
    tick(6);
    chk(!stStarted, "R3 level trigger ignored", {63'd0, stStarted}, 64'd0);
    trigIn = 1'b0; tick(2);
    trigIn = 1'b1; tick(2);
    for (int i = 0; i < NS + 4; i++) begin
      extSmpIn = 1'b1;
      chanIn = (i < NS) ? smp[i] : CH'($urandom);
      tick(3);
      extSmpIn = 1'b0;
      tick(3);
    end
    chk(wrCount == DEPTH, "R8 one sample per ext edge", 64'(wrCount), 64'(DEPTH));
    chk(addrErr == 0, "R5 restart at zero", 64'(addrErr), 64'd0);
    checkRam("R8 ext data");
    extSel = 1'b0;

    // capture 3: second internal run, short pre-trigger
    newSamples();
    wrCount = 0;
    trigIn = 1'b0;
    arm();
    tick(1 + ($urandom % 4));
    trigIn = 1'b1; chanIn = '1; tick(1);
    for (int i = 0; i < NS; i++) begin chanIn = smp[i]; tick(1); end
    tick(4);
    chk(wrCount == DEPTH && stFull, "R6 full again", 64'(wrCount), 64'(DEPTH));
    checkRam("R4 packing run 3");
    chk(addrErr == 0, "R5 wrap sequence", 64'(addrErr), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule